// File: doc/BRIEF.md
# Parallel NOR Flash Device Emulator

This block stands in for a small asynchronous 16-bit parallel NOR flash on the device side of a bus. A flash controller under test drives the address, data, chip-enable, output-enable, write-enable and reset pins as it would drive a real part. The emulator decodes the write cycles as commands, keeps a small internal word array, and answers reads according to its current read mode. That mode is array contents, identifier codes or the status word.

Contents change only through two operations. A block erase sets a whole block to ones. A single-word program can only clear bits. Each operation holds the device busy for a parameterised number of clock cycles, which stands in for the real device's long erase and program times. All pins are sampled on a free-running clock. A write cycle takes effect on the clock after write enable returns high, provided chip enable was low while write enable was low.

Top module: `nor_flash_model`

## Requirements
- R1: Command 0x20 followed by confirm 0xD0 erases the block containing the confirm address (blocks of 2^BLK_AW words), so every word reads 0xFFFF. Words in other blocks keep their values.
- R2: Command 0x40 followed by a data word at an address programs that word, and the stored value becomes the old value ANDed with the data word.
- R3: If the word after 0x20 is not 0xD0, no erase starts and the device stays ready. Status bit 5 (erase error) becomes 1, and the array is unchanged.
- R4: After command 0x90, reads return VENDOR_CODE at word address 0, DEVICE_CODE at word address 1 and zero at every other address.
- R5: Command 0x70 selects status reads at any address, and command 0xFF selects array reads. A read mode persists across reads until another command changes it. A setup command (0x20 or 0x40) also selects status reads.
- R6: Status bit 7 is 1 when ready and 0 when busy. After a confirmed erase the device is busy for exactly ERASE_CYCLES clocks, and after a program for exactly PROG_CYCLES clocks.
- R7: Write cycles issued while the device is busy are ignored. They change neither the read mode nor the array.
- R8: While RST# is low, any operation in progress is abandoned, leaving the array unchanged. Afterwards the device is in array read mode, ready, with the erase error bit cleared.
- R9: The data output enable is 1 only when CE# and OE# are low and WE# is high.
- R10: A write cycle is accepted only when CE# was low while WE# was low. A WE# pulse with CE# high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Device reset RST#, active low |
| addr | input | AW | Word address |
| data_in | input | DW | Data bus from the controller |
| data_out | output | DW | Data bus toward the controller |
| data_oe | output | 1 | Emulator drives the data bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |

## Verification
On every cycle, assertions check four things: the busy counter falls one step per clock, the read mode stays on status while busy, and the ready bit and identifier codes agree with the device state. They also check that a finished erase leaves ones in its block and that a finished program never raises a bit. What only the bench's scenarios can show is the command sequences as a whole. These are erase and program of every word followed by full read-back, a mistyped confirm, commands dropped while busy, a strobe with chip enable high, and a reset in the middle of an erase.

// File: rtl/nor_flash_model.sv
module nor_flash_model #(
  parameter int AW           = 6,
  parameter int DW           = 16,
  parameter int BLK_AW       = 4,
  parameter int ERASE_CYCLES = 2000,
  parameter int PROG_CYCLES  = 40,
  parameter logic [DW-1:0] VENDOR_CODE = 16'h0089,
  parameter logic [DW-1:0] DEVICE_CODE = 16'h881E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n
);
  localparam int WORDS     = 1 << AW;
  localparam int BLK_WORDS = 1 << BLK_AW;
  localparam int MAXC      = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW        = $clog2(MAXC + 1);

  typedef enum logic [1:0] {RD_ARRAY, RD_ID, RD_STATUS} rmode_t;
  typedef enum logic [1:0] {PN_NONE, PN_ERASE, PN_PROG} pend_t;

  logic [DW-1:0] mem [WORDS];
  logic          we_q, ce_q;
  logic [AW-1:0] addr_q, tgt_addr;
  logic [DW-1:0] din_q, tgt_data, sts;
  rmode_t        mode;
  pend_t         pend;
  logic [CW-1:0] cnt;
  logic          op_erase, err_erase;

  wire       wr_evt = !we_q && we_n && !ce_q;
  wire       busy   = cnt != '0;
  wire       fin    = rst_n && cnt == CW'(1);
  wire [7:0] cmd    = din_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      ce_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      we_q   <= we_n;
      ce_q   <= ce_n;
      addr_q <= addr;
      din_q  <= data_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= RD_ARRAY;
      pend      <= PN_NONE;
      cnt       <= '0;
      op_erase  <= 1'b0;
      err_erase <= 1'b0;
      tgt_addr  <= '0;
      tgt_data  <= '0;
    end else begin
      if (busy) cnt <= cnt - CW'(1);
      if (wr_evt && !busy) begin
        pend <= PN_NONE;
        case (pend)
          PN_ERASE: begin
            mode <= RD_STATUS;
            if (cmd == 8'hD0) begin
              cnt      <= CW'(ERASE_CYCLES);
              op_erase <= 1'b1;
              tgt_addr <= addr_q;
            end else begin
              err_erase <= 1'b1;
            end
          end
          PN_PROG: begin
            mode     <= RD_STATUS;
            cnt      <= CW'(PROG_CYCLES);
            op_erase <= 1'b0;
            tgt_addr <= addr_q;
            tgt_data <= din_q;
          end
          default: begin
            case (cmd)
              8'hFF: mode <= RD_ARRAY;
              8'h70: mode <= RD_STATUS;
              8'h90: mode <= RD_ID;
              8'h20: begin pend <= PN_ERASE; mode <= RD_STATUS; end
              8'h40: begin pend <= PN_PROG;  mode <= RD_STATUS; end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fin) begin
      if (op_erase) begin
        for (int b = 0; b < BLK_WORDS; b++)
          mem[{tgt_addr[AW-1:BLK_AW], BLK_AW'(b)}] <= '1;
      end else begin
        mem[tgt_addr] <= mem[tgt_addr] & tgt_data;
      end
    end
  end

  always_comb begin
    sts    = '0;
    sts[7] = !busy;
    sts[5] = err_erase;
  end

  always_comb begin
    case (mode)
      RD_ARRAY: data_out = mem[addr];
      RD_ID:    data_out = (addr == AW'(0)) ? VENDOR_CODE :
                           (addr == AW'(1)) ? DEVICE_CODE : '0;
      default:  data_out = sts;
    endcase
  end

  assign data_oe = !ce_n && !oe_n && we_n;

  p_busy_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt == $past(cnt) - CW'(1));
  p_status_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mode == RD_STATUS);
  p_ready_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RD_STATUS) |-> data_out[7] == (cnt == '0));
  p_vendor_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RD_ID && addr == AW'(0)) |-> data_out == VENDOR_CODE);
  p_erase_fills_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_erase) |=> mem[{tgt_addr[AW-1:BLK_AW], {BLK_AW{1'b0}}}] == '1);
  p_prog_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !op_erase) |=> (mem[tgt_addr] & ~$past(mem[tgt_addr])) == '0);
  p_prog_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !op_erase) |=> (mem[tgt_addr] & ~tgt_data) == '0);
endmodule

// File: tb/nor_flash_model_tb.sv
module nor_flash_model_tb;
  localparam int AW = 6, DW = 16, BLK_AW = 4, EC = 20, PC = 6;
  localparam int WORDS = 1 << AW;
  localparam logic [15:0] VEND = 16'h0089, DEV = 16'h881E;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0, data_out;
  logic data_oe;
  int checks = 0, errors = 0;
  logic [15:0] model [WORDS];

  always #2.5 clk = ~clk;

  nor_flash_model #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .ERASE_CYCLES(EC),
    .PROG_CYCLES(PC), .VENDOR_CODE(VEND), .DEVICE_CODE(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n));

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; data_in = d; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    #1 d = data_out;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_ready(output int n);
    logic [15:0] s;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      bus_read('0, s);
      if (s[7]) break;
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    bus_write('0, 16'h0070); bus_read('0, d);
    check(d == 16'h0080, "R8 reset status", d, 16'h0080);

    for (int c = 0; c < 8; c++) begin
      @(negedge clk); data_in = 16'h0000; ce_n = c[0]; oe_n = c[1]; we_n = c[2];
      #1 check(data_oe == (!c[0] && !c[1] && c[2]), "R9 oe gating", {15'b0, data_oe}, {15'b0, (!c[0] && !c[1] && c[2])});
    end
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;

    for (int b = 0; b < 4; b++) begin
      bus_write(AW'(b * 16), 16'h0020); bus_write(AW'(b * 16 + 3), 16'h00D0);
      wait_ready(n);
      check(n == EC, "R6 erase busy cycles", 16'(n), 16'(EC));
    end
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    bus_write('0, 16'h00FF);
    for (int i = 0; i < WORDS; i++) begin
      bus_read(AW'(i), d);
      check(d == 16'hFFFF, "R1 erased word", d, 16'hFFFF);
    end

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < WORDS; i++) begin
        logic [15:0] p;
        p = (pass == 0) ? (16'(i) * 16'h0101) ^ 16'h5A3C : ~(16'(i) * 16'h0F0F);
        bus_write(AW'(i), 16'h0040); bus_write(AW'(i), p);
        wait_ready(n);
        check(n == PC, "R6 program busy cycles", 16'(n), 16'(PC));
        model[i] = model[i] & p;
      end
      bus_write('0, 16'h00FF);
      for (int i = 0; i < WORDS; i++) begin
        bus_read(AW'(i), d);
        check(d == model[i], "R2 programmed word", d, model[i]);
      end
    end

    bus_write(AW'(32), 16'h0020); bus_write(AW'(40), 16'h00D0);
    wait_ready(n);
    for (int i = 32; i < 48; i++) model[i] = 16'hFFFF;
    bus_write('0, 16'h00FF);
    for (int i = 0; i < WORDS; i++) begin
      bus_read(AW'(i), d);
      check(d == model[i], "R1 single block erase", d, model[i]);
    end

    bus_write(AW'(0), 16'h0020); bus_write(AW'(0), 16'h00D0);
    bus_write(AW'(0), 16'h00FF);
    bus_write(AW'(20), 16'h0040); bus_write(AW'(20), 16'h0000);
    wait_ready(n);
    for (int i = 0; i < 16; i++) model[i] = 16'hFFFF;
    bus_read(AW'(5), d);
    check(d == 16'h0080, "R7 mode unchanged by busy writes", d, 16'h0080);
    bus_write('0, 16'h00FF);
    bus_read(AW'(20), d);
    check(d == model[20], "R7 program while busy ignored", d, model[20]);
    bus_read(AW'(7), d);
    check(d == 16'hFFFF, "R1 erase after busy writes", d, 16'hFFFF);

    bus_write(AW'(48), 16'h0020); bus_write(AW'(48), 16'h0033);
    bus_read(AW'(48), d);
    check(d == 16'h00A0, "R3 bad confirm status", d, 16'h00A0);
    bus_write('0, 16'h00FF);
    for (int i = 48; i < 64; i++) begin
      bus_read(AW'(i), d);
      check(d == model[i], "R3 array untouched", d, model[i]);
    end

    bus_write('0, 16'h0070);
    for (int i = 0; i < 4; i++) begin
      bus_read(AW'(i * 9), d);
      check(d == 16'h00A0, "R5 status persists", d, 16'h00A0);
    end
    bus_write('0, 16'h00FF);
    bus_read(AW'(9), d);
    check(d == model[9], "R5 back to array", d, model[9]);

    bus_write('0, 16'h0090);
    bus_read(AW'(0), d); check(d == VEND, "R4 vendor code", d, VEND);
    bus_read(AW'(1), d); check(d == DEV, "R4 device code", d, DEV);
    bus_read(AW'(2), d); check(d == 16'h0000, "R4 other offset", d, 16'h0000);
    bus_read(AW'(0), d); check(d == VEND, "R5 id persists", d, VEND);
    bus_write('0, 16'h00FF);

    @(negedge clk); addr = '0; data_in = 16'h0090; ce_n = 1; we_n = 0;
    @(negedge clk); we_n = 1;
    bus_read(AW'(0), d);
    check(d == model[0], "R10 write with CE high ignored", d, model[0]);

    bus_write(AW'(16), 16'h0020); bus_write(AW'(16), 16'h00D0);
    repeat (3) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    bus_read(AW'(16), d);
    check(d == model[16], "R8 aborted erase leaves array", d, model[16]);
    bus_read(AW'(63), d);
    check(d == model[63], "R8 array mode after reset", d, model[63]);
    bus_write('0, 16'h0070); bus_read('0, d);
    check(d == 16'h0080, "R8 ready and error cleared", d, 16'h0080);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule